// File: doc/BRIEF.md
# Multi-Plane Discrepancy Detector and Locator

This block sits in the output port of a switch whose fabric has several active planes and one spare plane. In each bit-clock cycle it takes one word from every active plane and one word from the spare plane. It follows the same schedule as the input-side copy logic, so it knows which active plane the spare word was copied from. It compares the two words and marks the plane as mismatching when any bit differs.

Mismatch marks stay set for a window of strobed cycles whose length is set on an input. When the window closes, the block decides where the fault lies. Exactly one disagreeing active plane points to that plane. Two or more distinct disagreeing planes point to the spare plane. The result goes to a fault-tolerance manager as a single-cycle pulse, and the marks are then cleared.

Two schedules are supported. In copy mode, cycle k of the stream checks active plane k mod M against the spare plane. In complement mode, each plane is visited for two cycles in a row. On the second cycle the active plane carries the inverse of the spare word from the first cycle, and the spare plane carries that plane's user data. The block restores that user data on its output.

Top module: `mp_discrepancy_locator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, fault_pulse, spare_bad and fault_idx are all 0.
- R2: In copy mode (mode=0), the k-th strobed cycle since reset compares spare_data with active plane k mod M only. A corrupted word on any other plane in that cycle raises no mark.
- R3: When exactly one active plane has mismatched during a window, the window's report has fault_pulse=1, spare_bad=0 and fault_idx set to that plane's index (plane p occupies act_data[p*W +: W]).
- R4: When two or more distinct active planes have mismatched during a window, the report has fault_pulse=1, spare_bad=1 and fault_idx=M.
- R5: A window with no mismatch produces no pulse.
- R6: In complement mode (mode=1), strobed cycles come in pairs, and pair j selects plane j mod M. A mismatch is marked on the second cycle of a pair when the selected active word is not the bitwise inverse of the spare word received in the first cycle.
- R7: In complement mode, on the second cycle of a pair, user_data equals act_data with the selected plane's slice replaced by spare_data. On all other cycles it equals act_data. This is combinational.
- R8: Cycles with valid=0 advance neither the schedule nor the window, and they raise no mark.
- R9: A window is win_len strobed cycles long (0 is treated as 1). The report is registered and appears in the cycle right after the closing strobed cycle. Marks from one window never carry into the next.
- R10: In copy mode, user_data equals act_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bit clock |
| rst_n | input | 1 | asynchronous active-low reset |
| mode | input | 1 | 0 copy schedule, 1 complement schedule |
| valid | input | 1 | strobe marking cycles that carry checked data |
| act_data | input | M*W | active-plane words, plane p at [p*W +: W] |
| spare_data | input | W | spare-plane word |
| win_len | input | CW | window length in strobed cycles |
| user_data | output | M*W | restored user data |
| fault_pulse | output | 1 | one-cycle location report |
| fault_idx | output | IW | faulty plane, M means spare |
| spare_bad | output | 1 | report points to the spare plane |

## Verification
user_data is combinational, so it is sampled a nanosecond after inputs change at the falling edge, before the next rising edge. The location report comes from one register stage after the closing strobed cycle. The bench therefore drives each cycle at the falling edge and samples fault_pulse, fault_idx and spare_bad just after the following rising edge. At that point it compares them with a reference window that it steps in the same cycle. Directed windows inject single-plane, spare and off-schedule corruption and idle strobes, and they pin the reported index to values worked out by hand.

// File: rtl/mp_discrepancy_locator.sv
module mp_discrepancy_locator #(
  parameter int M  = 4,
  parameter int W  = 4,
  parameter int CW = 8,
  parameter int IW = $clog2(M + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              valid,
  input  logic [M*W-1:0]    act_data,
  input  logic [W-1:0]      spare_data,
  input  logic [CW-1:0]     win_len,
  output logic [M*W-1:0]    user_data,
  output logic              fault_pulse,
  output logic [IW-1:0]     fault_idx,
  output logic              spare_bad
);
  localparam int SW = (M > 1) ? $clog2(M) : 1;
  localparam logic [SW-1:0] LAST = SW'(M - 1);

  logic [SW-1:0] sel;
  logic          phase;
  logic [W-1:0]  spare_q;
  logic [M-1:0]  marks;
  logic [CW-1:0] wcnt;

  logic [W-1:0]  act_sel;
  logic          chk, miss, close;
  logic [M-1:0]  hit, marks_n;
  logic [IW-1:0] nbad;
  logic [IW-1:0] first;

  assign act_sel = act_data[sel*W +: W];
  assign chk     = valid && (!mode || phase);
  assign miss    = chk && (mode ? (act_sel != ~spare_q) : (act_sel != spare_data));
  assign close   = valid && ((win_len == '0) || ({1'b0, wcnt} + 1'b1 >= {1'b0, win_len}));

  genvar g;
  generate
    for (g = 0; g < M; g++) begin : g_plane
      assign hit[g] = miss && (sel == SW'(g));
      assign user_data[g*W +: W] = (mode && phase && sel == SW'(g)) ? spare_data
                                                                     : act_data[g*W +: W];
    end
  endgenerate

  assign marks_n = marks | hit;

  always_comb begin
    nbad  = '0;
    first = '0;
    for (int i = M - 1; i >= 0; i--) begin
      if (marks_n[i]) begin
        nbad  = nbad + 1'b1;
        first = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= '0;
      phase   <= 1'b0;
      spare_q <= '0;
      marks   <= '0;
      wcnt    <= '0;
    end else if (valid) begin
      if (mode) begin
        phase <= ~phase;
        if (!phase) spare_q <= spare_data;
        else        sel     <= (sel == LAST) ? '0 : sel + 1'b1;
      end else begin
        sel <= (sel == LAST) ? '0 : sel + 1'b1;
      end
      wcnt  <= close ? '0 : wcnt + 1'b1;
      marks <= close ? '0 : marks_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_pulse <= 1'b0;
      spare_bad   <= 1'b0;
      fault_idx   <= '0;
    end else begin
      fault_pulse <= close && (nbad != '0);
      spare_bad   <= close && (nbad > IW'(1));
      fault_idx   <= !close ? '0 : (nbad > IW'(1)) ? IW'(M) : first;
    end
  end
endmodule

module mp_discrepancy_locator_chk #(
  parameter int M  = 4,
  parameter int W  = 4,
  parameter int CW = 8,
  parameter int IW = $clog2(M + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mode,
  input logic           valid,
  input logic [M*W-1:0] act_data,
  input logic [M*W-1:0] user_data,
  input logic           fault_pulse,
  input logic [IW-1:0]  fault_idx,
  input logic           spare_bad
);
  AST_SPARE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    spare_bad |-> (fault_pulse && fault_idx == IW'(M))); // R4

  AST_ACTIVE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pulse && !spare_bad) |-> (fault_idx < IW'(M))); // R3

  AST_QUIET_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_pulse |-> (fault_idx == '0 && !spare_bad)); // R5

  AST_IDLE_NO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !fault_pulse); // R8

  AST_COPY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> (user_data == act_data)); // R10
endmodule

bind mp_discrepancy_locator mp_discrepancy_locator_chk #(.M(M), .W(W), .CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .valid(valid), .act_data(act_data),
  .user_data(user_data), .fault_pulse(fault_pulse), .fault_idx(fault_idx), .spare_bad(spare_bad)
);

// File: tb/tb_mp_discrepancy_locator.sv
module tb_mp_discrepancy_locator;
  localparam int M  = 4;
  localparam int W  = 4;
  localparam int CW = 8;
  localparam int IW = $clog2(M + 1);

  logic clk = 0, rst_n = 0, mode = 0, valid = 0;
  logic [M*W-1:0] act_data = '0;
  logic [W-1:0]   spare_data = '0;
  logic [CW-1:0]  win_len = 8;
  logic [M*W-1:0] user_data;
  logic fault_pulse, spare_bad;
  logic [IW-1:0] fault_idx;

  int total = 0, bad = 0;
  bit done = 0;
  int seen_idx;
  bit seen_pulse, seen_sb;

  int b_sel; bit b_phase; logic [W-1:0] b_rsaved, b_gsaved;
  logic [M-1:0] b_marks; int b_wcnt;

  always #5 clk = ~clk;

  mp_discrepancy_locator #(.M(M), .W(W), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .valid(valid), .act_data(act_data),
    .spare_data(spare_data), .win_len(win_len), .user_data(user_data),
    .fault_pulse(fault_pulse), .fault_idx(fault_idx), .spare_bad(spare_bad));

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic int ones(input logic [M-1:0] v);
    int n = 0;
    for (int i = 0; i < M; i++) n += v[i];
    return n;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; valid = 0;
    b_sel = 0; b_phase = 0; b_rsaved = '0; b_gsaved = '0; b_marks = '0; b_wcnt = 0;
    #1;
    check(!fault_pulse && !spare_bad && fault_idx == 0, "R1 in reset", {fault_pulse, spare_bad, fault_idx}, 0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    check(!fault_pulse && !spare_bad && fault_idx == 0, "R1 after reset", {fault_pulse, spare_bad, fault_idx}, 0);
  endtask

  task automatic step(input bit v, input bit md, input logic [M*W-1:0] usr, input int fa, input bit fs);
    logic [M*W-1:0] a, eud;
    logic [W-1:0] s;
    logic [M-1:0] mn;
    bit miss, cl, ep, esb;
    int eidx, wl;
    @(negedge clk);
    a = usr;
    s = usr[b_sel*W +: W];
    if (md && b_phase) a[b_sel*W +: W] = ~b_gsaved;
    if (fa >= 0) a[fa*W +: W] = a[fa*W +: W] ^ W'(1);
    if (fs) s = s ^ W'(1);
    valid = v; mode = md; act_data = a; spare_data = s;
    #1;
    if (v) begin
      eud = a;
      if (md && b_phase) eud[b_sel*W +: W] = s;
      check(user_data == eud, md ? "R7 user data" : "R10 user data", user_data, eud);
      if (md && fa < 0 && !fs)
        check(user_data == usr, "R7 restored", user_data, usr);
    end
    wl = (win_len == 0) ? 1 : int'(win_len);
    miss = 0;
    if (v) miss = md ? (b_phase && a[b_sel*W +: W] != ~b_rsaved) : (a[b_sel*W +: W] != s);
    mn = b_marks;
    if (miss) mn[b_sel] = 1'b1;
    cl = v && (b_wcnt + 1 >= wl);
    ep = cl && (mn != 0);
    esb = ep && ones(mn) >= 2;
    eidx = 0;
    if (esb) eidx = M;
    else if (ep) for (int i = M - 1; i >= 0; i--) if (mn[i]) eidx = i;
    @(posedge clk); #1;
    check(fault_pulse == ep, ep ? "R9 pulse" : "R5 no pulse", fault_pulse, ep);
    check(spare_bad == esb, "R4 spare flag", spare_bad, esb);
    check(fault_idx == IW'(eidx), esb ? "R4 index" : "R3 index", fault_idx, eidx);
    if (fault_pulse) begin seen_pulse = 1; seen_idx = fault_idx; seen_sb = spare_bad; end
    if (v) begin
      if (md) begin
        if (!b_phase) begin b_rsaved = s; b_gsaved = usr[b_sel*W +: W]; end
        else b_sel = (b_sel + 1) % M;
        b_phase = !b_phase;
      end else b_sel = (b_sel + 1) % M;
      b_wcnt = cl ? 0 : b_wcnt + 1;
      b_marks = cl ? '0 : mn;
    end
  endtask

  function automatic logic [M*W-1:0] rnd();
    logic [M*W-1:0] r;
    for (int i = 0; i < M*W; i += 16) r[i +: 16] = 16'($urandom);
    return r;
  endfunction

  task automatic window(input bit md, input int fa_plane, input bit spare_f);
    seen_pulse = 0; seen_idx = -1; seen_sb = 0;
    for (int k = 0; k < 8; k++) step(1, md, rnd(), fa_plane, spare_f);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    do_reset();
    win_len = 8;

    window(0, -1, 0);
    check(!seen_pulse, "R5 clean copy window", seen_pulse, 0);

    window(0, 2, 0);
    check(seen_pulse && seen_idx == 2 && !seen_sb, "R3 plane 2", seen_idx, 2);

    window(0, -1, 1);
    check(seen_pulse && seen_idx == M && seen_sb, "R4 spare fault", seen_idx, M);

    seen_pulse = 0;
    for (int k = 0; k < 8; k++) step(1, 0, rnd(), (k % M == 1) ? 3 : -1, 0);
    check(!seen_pulse, "R2 off-schedule corruption", seen_pulse, 0);

    seen_pulse = 0;
    for (int k = 0; k < 8; k++) begin
      step(0, 0, rnd(), 1, 1);
      step(1, 0, rnd(), -1, 0);
    end
    check(!seen_pulse, "R8 idle strobes ignored", seen_pulse, 0);

    window(0, -1, 0);
    check(!seen_pulse, "R9 marks cleared", seen_pulse, 0);

    do_reset();
    window(1, -1, 0);
    check(!seen_pulse, "R5 clean complement window", seen_pulse, 0);

    seen_pulse = 0;
    for (int k = 0; k < 8; k++) step(1, 1, rnd(), (k == 3) ? 1 : -1, 0);
    check(seen_pulse && seen_idx == 1, "R6 complement mismatch", seen_idx, 1);

    seen_pulse = 0;
    for (int k = 0; k < 8; k++) step(1, 1, rnd(), (k == 2) ? 1 : -1, 0);
    check(!seen_pulse, "R6 first-of-pair not checked", seen_pulse, 0);

    win_len = 0;
    window(0, -1, 0);
    do_reset();
    win_len = 1;
    seen_pulse = 0;
    step(1, 0, rnd(), 0, 0);
    check(seen_pulse && seen_idx == 0, "R9 window of one", seen_idx, 0);

    for (int pass = 0; pass < 2; pass++) begin
      do_reset();
      win_len = CW'(3 + $urandom_range(0, 6));
      for (int n = 0; n < 600; n++) begin
        int f;
        f = ($urandom_range(0, 19) == 0) ? int'($urandom_range(0, M - 1)) : -1;
        step($urandom_range(0, 4) != 0, pass[0], rnd(), f, $urandom_range(0, 29) == 0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule